// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core's scheduler whether a memory instruction should wait for an older store that is still in flight. It learns which stores and loads have collided from memory-ordering violations. It groups the colliding instructions into store sets, and each set names the most recently dispatched store that belongs to it. When a later instruction of that set is dispatched, the block returns that store's sequence number, so the scheduler can hold the instruction until the store issues.

The block has two tables. The set table is indexed by instruction address and maps an address to a set number. The producer table is indexed by set number and holds the sequence number of the last dispatched store of the set. Each entry in both tables has its own valid bit. Four ports drive the tables: a dispatch port, which does the lookup and records stores; a violation port, which merges a store and a load into one set; an issue port, which retires a store from its set; and a squash port, which drops producers younger than a boundary. A dispatch counter clears all valid bits after a fixed number of memory operations, so that the predictor never reaches a state where every access is predicted dependent. A global flush input clears all state in one cycle.

Top module: `memdep_predictor`

## Requirements
- R1: The set-table index of an address is the field `pc[PC_SHIFT +: log2(ID_ENTRIES)]`. Addresses that differ only outside this field share an entry.
- R2: `disp_wait_seq` is combinational from the stored state. It shows the producer's sequence number when `disp_valid` is high, the set entry is valid and the producer entry of that set is valid. In every other case it is zero.
- R3: A dispatched store whose set entry is valid writes its sequence number into the producer entry of its set and marks that entry valid. A store whose set entry is invalid changes nothing.
- R4: A dispatched load changes no table state.
- R5: A violation in which neither PC has a valid set entry gives both entries the set number `(store_pc ^ (store_pc >> 10)) mod PROD_ENTRIES`.
- R6: A violation in which exactly one of the two PCs has a valid set entry copies that set number into the other entry.
- R7: A violation in which both PCs have valid set entries writes the smaller of the two set numbers into both entries.
- R8: An issued store whose set is valid invalidates its producer entry only if that entry holds the store's own sequence number. With any other number the entry stays valid.
- R9: A squash invalidates every producer entry whose sequence number is strictly greater than the boundary. An entry equal to the boundary stays valid.
- R10: Every CLEAR_PERIOD-th dispatch clears all valid bits in both tables and restarts the count. That dispatch's lookup still sees the state before the clear, and its store write is dropped.
- R11: `flush_all` clears all valid bits and the dispatch count at the next edge. After reset, every lookup returns zero.
- R12: When a store dispatch and a squash occur in the same cycle, the squash uses the old contents and the new producer write takes effect last. The newly dispatched store therefore survives the squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_all | input | 1 | Clears all predictor state at the next edge |
| disp_valid | input | 1 | A memory instruction is dispatched this cycle |
| disp_pc | input | PC_W | Address of the dispatched instruction |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction (nonzero) |
| disp_is_store | input | 1 | High for a store, low for a load |
| disp_wait_seq | output | SEQ_W | Sequence number of the store to wait for, zero if none |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_store_pc | input | PC_W | Address of the older store in the violation |
| viol_load_pc | input | PC_W | Address of the younger load in the violation |
| iss_valid | input | 1 | A memory instruction issues |
| iss_pc | input | PC_W | Address of the issuing instruction |
| iss_seq | input | SEQ_W | Sequence number of the issuing instruction |
| iss_is_store | input | 1 | High when the issuing instruction is a store |
| sq_valid | input | 1 | A squash is requested |
| sq_seq | input | SEQ_W | Squash boundary; producers younger than this are dropped |

## Verification
A store dispatch and a squash can arrive in the same cycle, and both act on the producer table. The bench first fills one producer entry and leaves a second, younger producer valid. In one cycle it then dispatches a store into the first set while squashing at a boundary below the new store's number. The lookup in that cycle must return the old producer, the next lookup of the first set must return the new store, and the second set must read back zero. A second collision, between a dispatch and the periodic clear, is provoked by counting dispatches up to the period. It is judged by a lookup in the clearing cycle, which must still hit, and a lookup one cycle later, which must miss.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

    // How a violation combines the current set numbers of its two PCs
    typedef enum logic [1:0] {
        MERGE_FRESH    = 2'd0,  // neither valid: hash a new set from the store
        MERGE_TO_LOAD  = 2'd1,  // only store valid: load copies it
        MERGE_TO_STORE = 2'd2,  // only load valid: store copies it
        MERGE_MIN      = 2'd3   // both valid: both take the smaller number
    } merge_e;

    function automatic merge_e merge_kind(input logic st_ok, input logic ld_ok);
        merge_e k;
        case ({st_ok, ld_ok})
            2'b00:   k = MERGE_FRESH;
            2'b10:   k = MERGE_TO_LOAD;
            2'b01:   k = MERGE_TO_STORE;
            default: k = MERGE_MIN;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/memdep_id_table.sv
module memdep_id_table
    import memdep_pkg::*;
#(
    parameter int ENTRIES  = 256,
    parameter int ID_W     = 6,
    parameter int PC_W     = 32,
    parameter int PC_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe,
    input  logic [PC_W-1:0]    rd_a_pc,
    output logic               rd_a_ok,
    output logic [ID_W-1:0]    rd_a_id,
    input  logic [PC_W-1:0]    rd_b_pc,
    output logic               rd_b_ok,
    output logic [ID_W-1:0]    rd_b_id,
    input  logic               viol_valid,
    input  logic [PC_W-1:0]    viol_st_pc,
    input  logic [PC_W-1:0]    viol_ld_pc,
    output logic [ENTRIES-1:0] vld_vec
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][ID_W-1:0] id;
    } tbl_t;

    tbl_t st_d, st_q;

    logic [IDX_W-1:0] vs_idx, vl_idx;
    logic             vs_ok, vl_ok;
    logic [ID_W-1:0]  vs_id, vl_id, merged_id;

    function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
        return pc[PC_SHIFT +: IDX_W];
    endfunction

    function automatic logic [ID_W-1:0] fresh_id(input logic [PC_W-1:0] pc);
        logic [PC_W-1:0] mix;
        mix = pc ^ (pc >> 10);
        return mix[ID_W-1:0];
    endfunction

    assign rd_a_ok = st_q.vld[pc_index(rd_a_pc)];
    assign rd_a_id = st_q.id[pc_index(rd_a_pc)];
    assign rd_b_ok = st_q.vld[pc_index(rd_b_pc)];
    assign rd_b_id = st_q.id[pc_index(rd_b_pc)];
    assign vld_vec = st_q.vld;

    always_comb begin
        st_d   = st_q;
        vs_idx = pc_index(viol_st_pc);
        vl_idx = pc_index(viol_ld_pc);
        vs_ok  = st_q.vld[vs_idx];
        vl_ok  = st_q.vld[vl_idx];
        vs_id  = st_q.id[vs_idx];
        vl_id  = st_q.id[vl_idx];
        case (merge_kind(vs_ok, vl_ok))
            MERGE_FRESH:    merged_id = fresh_id(viol_st_pc);
            MERGE_TO_LOAD:  merged_id = vs_id;
            MERGE_TO_STORE: merged_id = vl_id;
            default:        merged_id = (vs_id < vl_id) ? vs_id : vl_id;
        endcase
        if (viol_valid) begin
            st_d.vld[vs_idx] = 1'b1;
            st_d.id[vs_idx]  = merged_id;
            st_d.vld[vl_idx] = 1'b1;
            st_d.id[vl_idx]  = merged_id;
        end
        if (wipe) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/memdep_prod_table.sv
module memdep_prod_table #(
    parameter int ENTRIES = 64,
    parameter int SEQ_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe,
    input  logic [IDX_W-1:0]   rd_id,
    output logic               rd_ok,
    output logic [SEQ_W-1:0]   rd_seq,
    input  logic               ins_valid,
    input  logic [IDX_W-1:0]   ins_id,
    input  logic [SEQ_W-1:0]   ins_seq,
    input  logic               rel_valid,
    input  logic [IDX_W-1:0]   rel_id,
    input  logic [SEQ_W-1:0]   rel_seq,
    input  logic               sq_valid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic [ENTRIES-1:0] vld_vec
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][SEQ_W-1:0] seq;
    } tbl_t;

    tbl_t st_d, st_q;

    assign rd_ok   = st_q.vld[rd_id];
    assign rd_seq  = st_q.seq[rd_id];
    assign vld_vec = st_q.vld;

    always_comb begin
        st_d = st_q;
        // Invalidations look only at the old contents
        for (int e = 0; e < ENTRIES; e++) begin
            if (sq_valid && (st_q.seq[e] > sq_seq)) begin
                st_d.vld[e] = 1'b0;
            end
        end
        if (rel_valid && st_q.vld[rel_id] && (st_q.seq[rel_id] == rel_seq)) begin
            st_d.vld[rel_id] = 1'b0;
        end
        // A new producer is written last and survives same-cycle invalidation
        if (ins_valid) begin
            st_d.vld[ins_id] = 1'b1;
            st_d.seq[ins_id] = ins_seq;
        end
        if (wipe) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/memdep_clear_ctr.sv
module memdep_clear_ctr #(
    parameter int PERIOD = 4096,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             tick,
    output logic             wipe_tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    assign wipe_tick = tick && (st_q.cnt == CNT_W'(PERIOD - 1));
    assign count     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (flush || wipe_tick) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/memdep_predictor.sv
module memdep_predictor
    import memdep_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int SEQ_W        = 16,
    parameter int ID_ENTRIES   = 256,
    parameter int PROD_ENTRIES = 64,
    parameter int PC_SHIFT     = 2,
    parameter int CLEAR_PERIOD = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             disp_valid,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [SEQ_W-1:0] disp_seq,
    input  logic             disp_is_store,
    output logic [SEQ_W-1:0] disp_wait_seq,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_store_pc,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic             iss_valid,
    input  logic [PC_W-1:0]  iss_pc,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             iss_is_store,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq
);
    localparam int SET_W = $clog2(PROD_ENTRIES);
    localparam int CNT_W = $clog2(CLEAR_PERIOD + 1);

    logic                    wipe_all, period_wipe;
    logic                    disp_hit, iss_hit, prod_ok;
    logic [SET_W-1:0]        disp_id, iss_id;
    logic [SEQ_W-1:0]        prod_seq;
    logic [ID_ENTRIES-1:0]   id_vld;
    logic [PROD_ENTRIES-1:0] prod_vld;
    logic [CNT_W-1:0]        ctr_count;

    assign wipe_all = flush_all | period_wipe;

    memdep_id_table #(
        .ENTRIES (ID_ENTRIES),
        .ID_W    (SET_W),
        .PC_W    (PC_W),
        .PC_SHIFT(PC_SHIFT)
    ) u_ids (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe_all),
        .rd_a_pc   (disp_pc),
        .rd_a_ok   (disp_hit),
        .rd_a_id   (disp_id),
        .rd_b_pc   (iss_pc),
        .rd_b_ok   (iss_hit),
        .rd_b_id   (iss_id),
        .viol_valid(viol_valid),
        .viol_st_pc(viol_store_pc),
        .viol_ld_pc(viol_load_pc),
        .vld_vec   (id_vld)
    );

    memdep_prod_table #(
        .ENTRIES(PROD_ENTRIES),
        .SEQ_W  (SEQ_W),
        .IDX_W  (SET_W)
    ) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe_all),
        .rd_id    (disp_id),
        .rd_ok    (prod_ok),
        .rd_seq   (prod_seq),
        .ins_valid(disp_valid & disp_is_store & disp_hit),
        .ins_id   (disp_id),
        .ins_seq  (disp_seq),
        .rel_valid(iss_valid & iss_is_store & iss_hit),
        .rel_id   (iss_id),
        .rel_seq  (iss_seq),
        .sq_valid (sq_valid),
        .sq_seq   (sq_seq),
        .vld_vec  (prod_vld)
    );

    memdep_clear_ctr #(
        .PERIOD(CLEAR_PERIOD),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_all),
        .tick     (disp_valid),
        .wipe_tick(period_wipe),
        .count    (ctr_count)
    );

    assign disp_wait_seq = (disp_valid && disp_hit && prod_ok) ? prod_seq : '0;

endmodule

// File: rtl/memdep_predictor_chk.sv
module memdep_predictor_chk #(
    parameter int SEQ_W        = 16,
    parameter int ID_ENTRIES   = 256,
    parameter int PROD_ENTRIES = 64,
    parameter int CLEAR_PERIOD = 4096,
    parameter int SET_W        = $clog2(PROD_ENTRIES),
    parameter int CNT_W        = $clog2(CLEAR_PERIOD + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    disp_valid,
    input logic                    disp_is_store,
    input logic                    disp_hit,
    input logic [SET_W-1:0]        disp_id,
    input logic [SEQ_W-1:0]        disp_wait_seq,
    input logic                    viol_valid,
    input logic                    iss_valid,
    input logic                    sq_valid,
    input logic                    wipe_all,
    input logic [ID_ENTRIES-1:0]   id_vld,
    input logic [PROD_ENTRIES-1:0] prod_vld,
    input logic [CNT_W-1:0]        ctr_count
);
    AST_EMPTY_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld == '0) |-> (disp_wait_seq == '0)); // R2

    AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> (disp_wait_seq == '0)); // R2

    AST_STORE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_is_store && disp_hit && !wipe_all) |=> prod_vld[$past(disp_id)]); // R3

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_is_store && !viol_valid && !iss_valid && !sq_valid && !wipe_all)
        |=> ($stable(prod_vld) && $stable(id_vld))); // R4

    AST_VIOL_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !wipe_all) |=> (id_vld != '0)); // R5

    AST_SQUASH_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !disp_valid) |=> ($countones(prod_vld) <= $past($countones(prod_vld)))); // R9

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_all |=> ((prod_vld == '0) && (id_vld == '0))); // R10

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_count < CNT_W'(CLEAR_PERIOD)); // R10

endmodule

bind memdep_predictor memdep_predictor_chk #(
    .SEQ_W       (SEQ_W),
    .ID_ENTRIES  (ID_ENTRIES),
    .PROD_ENTRIES(PROD_ENTRIES),
    .CLEAR_PERIOD(CLEAR_PERIOD)
) u_chk (.*);

// File: tb/memdep_predictor_test.sv
`timescale 1ns/1ps
module memdep_predictor_test;
    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;
    localparam int PERIOD = 40;

    localparam logic [1:0] OP_DISP = 2'd0;
    localparam logic [1:0] OP_VIOL = 2'd1;
    localparam logic [1:0] OP_ISS  = 2'd2;
    localparam logic [1:0] OP_SQ   = 2'd3;

    // Set table 16 entries (index = pc[5:2]), producer table 8 entries (hash low 3 bits)
    localparam logic [31:0] S1 = 32'h14;   // index 5, hash 4
    localparam logic [31:0] L1 = 32'h28;   // index 10
    localparam logic [31:0] S2 = 32'h30;   // index 12
    localparam logic [31:0] L2 = 32'h3C;   // index 15
    localparam logic [31:0] S3 = 32'h40C;  // index 3, hash 5

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        st;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{OP_DISP, L1, 32'd10, 1'b0, 16'd0,  4'd2},  // R2 set entry invalid
        '{OP_DISP, S1, 32'd11, 1'b1, 16'd0,  4'd3},  // R3 store without set: no write
        '{OP_DISP, L1, 32'd12, 1'b0, 16'd0,  4'd2},
        '{OP_VIOL, S1, L1,     1'b0, 16'd0,  4'd5},  // R5 both get set 4
        '{OP_DISP, L1, 32'd20, 1'b0, 16'd0,  4'd3},  // R3 seq 11 was not recorded
        '{OP_DISP, S1, 32'd21, 1'b1, 16'd0,  4'd2},  // producer invalid; records 21
        '{OP_DISP, L1, 32'd22, 1'b0, 16'd21, 4'd3},  // R3
        '{OP_DISP, L1, 32'd23, 1'b0, 16'd21, 4'd4},  // R4 load left it intact
        '{OP_ISS,  S1, 32'd99, 1'b1, 16'd0,  4'd8},  // R8 wrong seq
        '{OP_DISP, L1, 32'd24, 1'b0, 16'd21, 4'd8},
        '{OP_ISS,  S1, 32'd21, 1'b1, 16'd0,  4'd8},  // R8 own seq
        '{OP_DISP, L1, 32'd25, 1'b0, 16'd0,  4'd8},
        '{OP_VIOL, S2, L1,     1'b0, 16'd0,  4'd6},  // R6 store copies set 4
        '{OP_DISP, S2, 32'd30, 1'b1, 16'd0,  4'd6},
        '{OP_DISP, L1, 32'd31, 1'b0, 16'd30, 4'd6},  // R6
        '{OP_VIOL, S3, L2,     1'b0, 16'd0,  4'd5},  // R5 both get set 5
        '{OP_DISP, S3, 32'd40, 1'b1, 16'd0,  4'd5},
        '{OP_DISP, L2, 32'd41, 1'b0, 16'd40, 4'd5},  // R5
        '{OP_VIOL, S1, L2,     1'b0, 16'd0,  4'd7},  // R7 min(4,5) = 4
        '{OP_DISP, L2, 32'd42, 1'b0, 16'd30, 4'd7},  // R7
        '{OP_SQ,   32'd0, 32'd30, 1'b0, 16'd0, 4'd9},// R9 drops 40, keeps 30
        '{OP_DISP, L1, 32'd43, 1'b0, 16'd30, 4'd9},  // R9 equal kept
        '{OP_DISP, S3, 32'd41, 1'b1, 16'd0,  4'd9},  // R9 younger dropped; records 41
        '{OP_DISP, 32'h2A, 32'd44, 1'b0, 16'd30, 4'd1}, // R1 low bits ignored
        '{OP_DISP, 32'h68, 32'd45, 1'b0, 16'd30, 4'd1}  // R1 high bits ignored
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             flush_all;
    logic             disp_valid, disp_is_store;
    logic [PC_W-1:0]  disp_pc;
    logic [SEQ_W-1:0] disp_seq, disp_wait_seq;
    logic             viol_valid;
    logic [PC_W-1:0]  viol_store_pc, viol_load_pc;
    logic             iss_valid, iss_is_store;
    logic [PC_W-1:0]  iss_pc;
    logic [SEQ_W-1:0] iss_seq;
    logic             sq_valid;
    logic [SEQ_W-1:0] sq_seq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    memdep_predictor #(
        .PC_W(PC_W), .SEQ_W(SEQ_W), .ID_ENTRIES(16), .PROD_ENTRIES(8),
        .PC_SHIFT(2), .CLEAR_PERIOD(PERIOD)
    ) uut (.*);

    task automatic idle_inputs();
        flush_all = 1'b0; disp_valid = 1'b0; disp_is_store = 1'b0;
        disp_pc = '0; disp_seq = '0; viol_valid = 1'b0;
        viol_store_pc = '0; viol_load_pc = '0; iss_valid = 1'b0;
        iss_is_store = 1'b0; iss_pc = '0; iss_seq = '0;
        sq_valid = 1'b0; sq_seq = '0;
    endtask

    task automatic check(input int req, input logic [SEQ_W-1:0] got, input logic [SEQ_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: disp_wait_seq=%0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        idle_inputs();
        case (v.op)
            OP_DISP: begin
                disp_valid = 1'b1; disp_pc = v.a; disp_seq = v.b[SEQ_W-1:0];
                disp_is_store = v.st;
            end
            OP_VIOL: begin
                viol_valid = 1'b1; viol_store_pc = v.a; viol_load_pc = v.b;
            end
            OP_ISS: begin
                iss_valid = 1'b1; iss_pc = v.a; iss_seq = v.b[SEQ_W-1:0];
                iss_is_store = v.st;
            end
            default: begin
                sq_valid = 1'b1; sq_seq = v.b[SEQ_W-1:0];
            end
        endcase
        #1;
        if (v.op == OP_DISP) check(int'(v.req), disp_wait_seq, v.exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: empty after reset
        apply('{OP_DISP, L1, 32'd5, 1'b0, 16'd0, 4'd11});

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R12: store dispatch and squash in one cycle; lookup still sees 30
        @(negedge clk);
        idle_inputs();
        disp_valid = 1'b1; disp_pc = S1; disp_seq = 16'd50; disp_is_store = 1'b1;
        sq_valid = 1'b1; sq_seq = 16'd35;
        #1 check(12, disp_wait_seq, 16'd30);
        apply('{OP_DISP, L1, 32'd51, 1'b0, 16'd50, 4'd12}); // R12 new store survives
        apply('{OP_DISP, S3, 32'd52, 1'b0, 16'd0,  4'd9});  // R9 seq 41 squashed

        // R11: flush clears everything
        @(negedge clk);
        idle_inputs();
        flush_all = 1'b1;
        apply('{OP_DISP, L1, 32'd53, 1'b0, 16'd0, 4'd11});   // count 1

        // R10: periodic clear on the PERIOD-th dispatch
        apply('{OP_VIOL, S1, L1, 1'b0, 16'd0, 4'd10});
        apply('{OP_DISP, S1, 32'd60, 1'b1, 16'd0, 4'd10});   // count 2
        apply('{OP_DISP, L1, 32'd61, 1'b0, 16'd60, 4'd10});  // count 3
        for (int k = 0; k < PERIOD - 4; k++) begin
            apply('{OP_DISP, 32'h100, 32'd62, 1'b0, 16'd0, 4'd10});
        end
        apply('{OP_DISP, L1, 32'd63, 1'b0, 16'd60, 4'd10});  // R10 clearing cycle
        apply('{OP_DISP, L1, 32'd64, 1'b0, 16'd0,  4'd10});  // R10 after clear
        apply('{OP_VIOL, S1, L1, 1'b0, 16'd0, 4'd10});
        apply('{OP_DISP, S1, 32'd70, 1'b1, 16'd0, 4'd10});
        apply('{OP_DISP, L1, 32'd71, 1'b0, 16'd70, 4'd10});  // R10 relearns after restart

        @(negedge clk);
        idle_inputs();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule